// File: doc/BRIEF.md
# Encoded Reference Frequency Divider

This block turns a reference clock, taken from a crystal oscillator or from an external source, into the comparison-rate strobe used by a frequency synthesizer's phase comparator. Each division period ends with a strobe exactly one reference cycle wide. The same strobe can be gated onto a test output when a select input is high.

A 5-bit ratio code sets the division ratio. The code is not a binary count. The upper two bits pick a base factor of 1, 5, 6 or 7. The lower three bits pick a power-of-two multiplier. For base 1 the multiplier is 2^(low+1). For the other bases it is 2^(low-1). A zero low field is therefore only valid with base 1, which leaves 29 usable ratios between 2 and 448.

Codes that would need base 5, 6 or 7 with a zero low field are rejected. They raise an error flag, and the divider keeps running at the last legal ratio. A new legal ratio is latched, but the period already counting is never cut short. The new ratio starts at a strobe boundary.

Top module: `refclk_divider`

## Requirements
- R1: With code bits [4:3] = 00, code bits [2:0] = k (0..7) give a strobe period of 2^(k+1) reference cycles, so 2 to 256.
- R2: With code bits [4:3] = 01 and bits [2:0] = k (1..7), the period is 5·2^(k-1), so 5 to 320.
- R3: With code bits [4:3] = 10 and bits [2:0] = k (1..7), the period is 6·2^(k-1), so 6 to 384.
- R4: With code bits [4:3] = 11 and bits [2:0] = k (1..7), the period is 7·2^(k-1), so 7 to 448.
- R5: code_err_o is high in the cycle after a clock edge that sampled an illegal code (bits [4:3] non-zero and bits [2:0] zero), and low after an edge that sampled a legal code.
- R6: While an illegal code is applied, the strobe period stays at the last legal ratio.
- R7: A code change made during a strobe cycle leaves the following period at the old ratio. Every period after that uses the new ratio, and no period is truncated.
- R8: fcomp_o is high for exactly one reference cycle per period and never for two consecutive cycles.
- R9: test_o equals fcomp_o while test_sel_i is high, and is held low while test_sel_i is low.
- R10: During reset fcomp_o, test_o and code_err_o are low. After reset the divider runs at the ratio of the reset code (default 00000, a period of 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_code | input | 5 | Encoded division ratio selector |
| test_sel_i | input | 1 | Routes the strobe to the test output when high |
| fcomp_o | output | 1 | Comparison strobe, one cycle wide, once per period |
| test_o | output | 1 | Gated copy of the strobe for a test port |
| code_err_o | output | 1 | High while the sampled code is illegal |

## Verification
The properties assume that ratio_code is synchronous to clk_ref and holds a defined value from reset onward. Under that assumption the sampled code always decodes to either a legal ratio or the flagged illegal group. The bench changes the code only half a cycle after a strobe edge, so every change lands inside a strobe cycle. That placement makes the old-ratio-then-new-ratio sequence exact rather than ambiguous. Illegal codes are presented only while a legal ratio is already held, which is the condition the hold behaviour relies on.

// File: rtl/refclk_div_pkg.sv
package refclk_div_pkg;

   localparam int CODE_W    = 5;
   localparam int MIN_W     = 9;
   localparam int MAX_RATIO = 448;

   // base factor picked by the two upper code bits
   function automatic logic [2:0] base_factor(input logic [1:0] grp);
      case (grp)
         2'b00:   return 3'd1;
         2'b01:   return 3'd5;
         2'b10:   return 3'd6;
         default: return 3'd7;
      endcase
   endfunction

   // legal unless a non-unity base is paired with a zero exponent field
   function automatic logic code_legal(input logic [CODE_W-1:0] c);
      return (c[4:3] == 2'b00) || (c[2:0] != 3'd0);
   endfunction

   // exponent applied to the base factor
   function automatic logic [3:0] code_shift(input logic [CODE_W-1:0] c);
      if (c[4:3] == 2'b00)
         return {1'b0, c[2:0]} + 4'd1;
      else
         return {1'b0, c[2:0]} - 4'd1;
   endfunction

   // ratio as integer, zero for illegal codes
   function automatic int code_ratio(input logic [CODE_W-1:0] c);
      if (!code_legal(c))
         return 0;
      return int'(base_factor(c[4:3])) << code_shift(c);
   endfunction

endpackage

// File: rtl/refclk_div_decode.sv
module refclk_div_decode
   import refclk_div_pkg::*;
#(
   parameter int RATIO_W = 9
) (
   input  logic [CODE_W-1:0]  code_i,
   output logic [RATIO_W-1:0] ratio_o,
   output logic               legal_o
);

   logic [3:0]         shamt;
   logic [RATIO_W-1:0] base_w;

   always_comb begin
      legal_o = code_legal(code_i);
      shamt   = code_shift(code_i);
      base_w  = RATIO_W'(base_factor(code_i[4:3]));
      ratio_o = legal_o ? (base_w << shamt) : '0;
   end

endmodule

// File: rtl/refclk_div_hold.sv
module refclk_div_hold #(
   parameter int RATIO_W   = 9,
   parameter int RST_RATIO = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic               legal_i,
   output logic [RATIO_W-1:0] held_o,
   output logic               err_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_o <= RATIO_W'(RST_RATIO);
         err_o  <= 1'b0;
      end else begin
         err_o <= !legal_i;
         if (legal_i)
            held_o <= ratio_i;
      end
   end

endmodule

// File: rtl/refclk_div_count.sv
module refclk_div_count #(
   parameter int RATIO_W   = 9,
   parameter int RST_RATIO = 2,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               strobe_o
);

   logic [RATIO_W-1:0] cnt_q;
   logic               at_end;

   assign at_end = (cnt_q == '0);

   // the next ratio is only picked up when the count wraps
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= RATIO_W'(RST_RATIO - 1);
      else if (at_end)
         cnt_q <= ratio_i - RATIO_W'(1);
      else
         cnt_q <= cnt_q - RATIO_W'(1);
   end

   generate
      if (OUT_REG) begin : g_reg_out
         logic strobe_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               strobe_q <= 1'b0;
            else
               strobe_q <= at_end;
         end
         assign strobe_o = strobe_q;
      end else begin : g_comb_out
         assign strobe_o = at_end && rst_n;
      end
   endgenerate

endmodule

// File: rtl/refclk_divider.sv
module refclk_divider
   import refclk_div_pkg::*;
#(
   parameter int              RATIO_W  = 9,
   parameter logic [4:0]      RST_CODE = 5'b00000,
   parameter bit              OUT_REG  = 1'b0
) (
   input  logic        clk_ref,
   input  logic        rst_n,
   input  logic [4:0]  ratio_code,
   input  logic        test_sel_i,
   output logic        fcomp_o,
   output logic        test_o,
   output logic        code_err_o
);

   localparam int RST_RATIO = code_ratio(RST_CODE);

   generate
      if (RATIO_W < MIN_W) begin : g_bad_width
         $error("refclk_divider: RATIO_W too small for the largest ratio");
      end
      if (!code_legal(RST_CODE)) begin : g_bad_code
         $error("refclk_divider: RST_CODE is not a legal ratio code");
      end
   endgenerate

   logic [RATIO_W-1:0] dec_ratio;
   logic               dec_legal;
   logic [RATIO_W-1:0] held_ratio;
   logic               strobe;

   refclk_div_decode #(.RATIO_W(RATIO_W)) u_decode (
      .code_i  (ratio_code),
      .ratio_o (dec_ratio),
      .legal_o (dec_legal)
   );

   refclk_div_hold #(.RATIO_W(RATIO_W), .RST_RATIO(RST_RATIO)) u_hold (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .ratio_i (dec_ratio),
      .legal_i (dec_legal),
      .held_o  (held_ratio),
      .err_o   (code_err_o)
   );

   refclk_div_count #(.RATIO_W(RATIO_W), .RST_RATIO(RST_RATIO), .OUT_REG(OUT_REG)) u_count (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .ratio_i  (held_ratio),
      .strobe_o (strobe)
   );

   assign fcomp_o = strobe;
   assign test_o  = strobe && test_sel_i;

endmodule

// File: rtl/refclk_divider_chk.sv
module refclk_divider_chk
   import refclk_div_pkg::*;
(
   input logic       clk_ref,
   input logic       rst_n,
   input logic [4:0] ratio_code,
   input logic       test_sel_i,
   input logic       fcomp_o,
   input logic       test_o,
   input logic       code_err_o
);

   logic [9:0] gap_q;

   always_ff @(posedge clk_ref) begin
      if (!rst_n)
         gap_q <= '0;
      else if (fcomp_o)
         gap_q <= '0;
      else
         gap_q <= gap_q + 10'd1;
   end

   // R8
   narrow_strobe_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      fcomp_o |=> !fcomp_o);

   // R4
   gap_bound_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      gap_q < 10'(MAX_RATIO));

   // R5
   err_rise_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(code_err_o) |-> $past(ratio_code[4:3] != 2'b00 && ratio_code[2:0] == 3'd0));

   // R5
   err_fall_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $fell(code_err_o) |-> $past(ratio_code[4:3] == 2'b00 || ratio_code[2:0] != 3'd0));

   // R9
   test_quiet_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !test_sel_i |-> !test_o);

   // R9
   test_follow_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (test_sel_i && fcomp_o) |-> test_o);

endmodule

bind refclk_divider refclk_divider_chk u_chk (
   .clk_ref    (clk_ref),
   .rst_n      (rst_n),
   .ratio_code (ratio_code),
   .test_sel_i (test_sel_i),
   .fcomp_o    (fcomp_o),
   .test_o     (test_o),
   .code_err_o (code_err_o)
);

// File: tb/refclk_divider_tb.sv
module refclk_divider_tb;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      int    period;
      string req;
   } exp_t;

   logic       clk_ref = 1'b0;
   logic       rst_n   = 1'b0;
   logic [4:0] ratio_code = 5'b00000;
   logic       test_sel_i = 1'b0;
   logic       fcomp_o;
   logic       test_o;
   logic       code_err_o;

   int   errors = 0;
   int   checks = 0;
   int   cyc    = 0;
   int   last   = 0;
   bit   have_last = 0;
   bit   prev_f = 0;
   int   cur    = 2;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

   refclk_divider u_dut (
      .clk_ref    (clk_ref),
      .rst_n      (rst_n),
      .ratio_code (ratio_code),
      .test_sel_i (test_sel_i),
      .fcomp_o    (fcomp_o),
      .test_o     (test_o),
      .code_err_o (code_err_o)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int model(logic [4:0] c);
      int b;
      case (c[4:3])
         2'b00:   b = 2;
         2'b01:   b = 5;
         2'b10:   b = 6;
         default: b = 7;
      endcase
      if (c[4:3] == 2'b00) return b << c[2:0];
      return b << (c[2:0] - 1);
   endfunction

   // monitor: measures strobe periods and pops expectations
   always @(negedge clk_ref) begin
      if (!rst_n) begin
         have_last = 0;
         prev_f    = 0;
         cyc       = 0;
      end else begin
         cyc++;
         if (test_sel_i || fcomp_o)
            check("R9", int'(test_o), int'(test_sel_i & fcomp_o));
         if (fcomp_o && prev_f)
            check("R8", 2, 1);
         if (fcomp_o) begin
            if (have_last && q.size() > 0) begin
               exp_t e;
               e = q.pop_front();
               check(e.req, cyc - last, e.period);
            end
            have_last = 1;
            last      = cyc;
         end
         prev_f = fcomp_o;
      end
   end

   task automatic apply(logic [4:0] c, int n, string req);
      bit legal;
      do @(negedge clk_ref); while (fcomp_o !== 1'b1);
      #1;
      ratio_code = c;
      legal = (c[4:3] == 2'b00) || (c[2:0] != 3'd0);
      q.push_back('{cur, "R7"});
      if (legal) cur = model(c);
      for (int i = 0; i < n; i++)
         q.push_back('{cur, legal ? req : "R6"});
      @(negedge clk_ref);
      check("R5", int'(code_err_o), int'(!legal));
      while (q.size() != 0) @(negedge clk_ref);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk_ref);
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk_ref);
      // R10 reset state
      check("R10", int'(fcomp_o), 0);
      check("R10", int'(test_o), 0);
      check("R10", int'(code_err_o), 0);
      @(negedge clk_ref);
      rst_n = 1'b1;
      // R10 / R1: reset ratio of 2 then binary group
      apply(5'b00000, 3, "R1");
      apply(5'b00111, 2, "R1");
      apply(5'b00011, 2, "R1");
      test_sel_i = 1'b1;
      // R2 group
      apply(5'b01001, 3, "R2");
      apply(5'b01111, 2, "R2");
      // R3 group
      apply(5'b10001, 3, "R3");
      apply(5'b10111, 2, "R3");
      test_sel_i = 1'b0;
      // R4 group
      apply(5'b11001, 3, "R4");
      apply(5'b11111, 2, "R4");
      apply(5'b11011, 2, "R4");
      // R5 / R6 illegal codes hold 28
      apply(5'b01000, 2, "R6");
      apply(5'b10000, 2, "R6");
      apply(5'b11000, 2, "R6");
      // legal again clears the flag
      apply(5'b00001, 3, "R1");
      test_sel_i = 1'b1;
      apply(5'b10010, 2, "R3");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule